// File: doc/BRIEF.md
# Bus-to-DMA Window Address Translator

This block sits between an expansion bus and system memory and turns each incoming bus address into a system DMA address. Four programmable windows each own a base register, a mask register and a translated-base register. A window either relocates the address directly or resolves it through a page table in memory. For a page-table lookup the block issues one 64-bit read on its memory read port and builds the output address from the returned entry.

Software programs the windows and a control register through a 64-bit register port. The register offset is the access address minus the block's base address, shifted right by six. Translation requests arrive on a valid/ready channel and results leave on another. Only one translation is in flight at a time, so the input channel is stalled while a page-table read is outstanding and while a result waits to be taken.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset the control register reads 0x0000_0021_0010_0000 (bit 20 and bit 32 set, value 2 in the field starting at bit 36), every window register reads zero, the input is ready, and no output or memory request is valid.
- R2: A register access with `reg_req` high selects offset (`reg_addr` − base) >> 6. Offset 0 is control, 1..4 are window bases 0..3, 5..8 are window masks 0..3 and 9..12 are translated bases 0..3. A read returns the data with `reg_rvalid` one cycle later. An access whose size is not 8 bytes, or whose offset is unmapped, raises `reg_err` one cycle later and changes no register.
- R3: Window i matches when the bus address and its base register agree on every bit of 31:20 whose mask bit is clear. Bits below 20 are never compared.
- R4: Windows are tried from index 0 upward. The first matching window whose base bit 0 (enable) is set translates. A matching window with bit 0 clear is skipped.
- R5: With base bit 1 clear the window maps directly. With keep = (mask & 0xFFF00000) | 0xFFFFF, the result is (translated base & ~keep) | (bus address & keep).
- R6: With base bit 1 set, the block drives a memory read of address (translated base & ~(((mask & 0xFFF00000) >> 10) | 0x3FF)) | ((bus address & ((mask & 0xFFF00000) | 0xFE000)) >> 10). It holds the request and its address stable until `mem_req_ready`, and keeps the input stalled until the response arrives.
- R7: After a page-table read, the result is ((entry with bit 0 cleared) << 12) | bus address bits 12:0.
- R8: Every translated result is truncated to its low 34 bits.
- R9: When no enabled window matches, the result equals the bus address, zero-extended, and no memory read is issued.
- R10: A result stays valid with a stable address until `xl_out_ready` is seen. The input is never ready while a result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW | Byte address of the access |
| reg_size | input | 4 | Access size in bytes (only 8 legal) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data |
| reg_rvalid | output | 1 | Read data valid |
| reg_err | output | 1 | Illegal size or unmapped offset |
| xl_in_valid | input | 1 | Translation request valid |
| xl_in_ready | output | 1 | Translator can take a request |
| xl_in_addr | input | BUS_AW | Bus address to translate |
| xl_out_valid | output | 1 | Result valid |
| xl_out_ready | input | 1 | Consumer takes the result |
| xl_out_addr | output | OUT_AW | Translated address |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Page-table entry address |
| mem_rsp_valid | input | 1 | Page-table entry returned |
| mem_rsp_data | input | 64 | Page-table entry |

## Verification
The hardest situation to reach is a page-table walk under back-pressure on both sides. The memory request has to be held across a cycle with no ready, and the input has to stay stalled through the fetch and then through a result the consumer refuses for several cycles. The stimulus first programs a page-table window whose translated base and entry push the result past 34 bits. It then withholds `mem_req_ready` for a cycle, returns the entry, and keeps `xl_out_ready` low while sampling the held address and the stalled input. A disabled window that shadows an enabled one covers the priority skip.

// File: rtl/dwx_pkg.sv
`timescale 1ns/1ps
package dwx_pkg;
    localparam int NWIN = 4;
    localparam logic [63:0] CMP_FIELD  = 64'h0000_0000_FFF0_0000;
    localparam logic [63:0] LOW_KEEP   = 64'h0000_0000_000F_FFFF;
    localparam logic [63:0] PT_IDX     = 64'h0000_0000_000F_E000;
    localparam logic [63:0] PT_ALIGN   = 64'h0000_0000_0000_03FF;
    localparam logic [63:0] CTRL_RESET = 64'h0000_0021_0010_0000;

    typedef logic [63:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_OUT
    } xl_state_e;
endpackage

// File: rtl/dwx_regs.sv
`timescale 1ns/1ps
module dwx_regs
    import dwx_pkg::*;
#(
    parameter int REG_AW = 16,
    parameter logic [REG_AW-1:0] BLK_BASE = 'h1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_req,
    input  logic                   reg_we,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic [3:0]             reg_size,
    input  word_t                  reg_wdata,
    output word_t                  reg_rdata,
    output logic                   reg_rvalid,
    output logic                   reg_err,
    output word_t [NWIN-1:0]       win_base,
    output word_t [NWIN-1:0]       win_mask,
    output word_t [NWIN-1:0]       win_xbase
);
    localparam int OFF_CTRL  = 0;
    localparam int OFF_BASE  = 1;
    localparam int OFF_MASK  = OFF_BASE + NWIN;
    localparam int OFF_XBASE = OFF_MASK + NWIN;

    typedef struct packed {
        word_t [NWIN-1:0] base;
        word_t [NWIN-1:0] mask;
        word_t [NWIN-1:0] xbase;
        word_t            ctrl;
        word_t            rdata;
        logic             rvalid;
        logic             err;
    } regs_t;

    regs_t q, d;

    logic [REG_AW-1:0] rel;
    logic [REG_AW-1:0] off;
    logic              legal;
    logic              mapped;
    word_t             rd;

    always_comb begin
        d         = q;
        d.rvalid  = 1'b0;
        d.err     = 1'b0;
        rel       = reg_addr - BLK_BASE;
        off       = rel >> 6;
        legal     = (reg_size == 4'd8);
        mapped    = 1'b0;
        rd        = '0;
        if (reg_req) begin
            if (off == REG_AW'(OFF_CTRL)) begin
                mapped = 1'b1;
                rd     = q.ctrl;
                if (reg_we && legal) d.ctrl = reg_wdata;
            end
            for (int i = 0; i < NWIN; i++) begin
                if (off == REG_AW'(OFF_BASE + i)) begin
                    mapped = 1'b1;
                    rd     = q.base[i];
                    if (reg_we && legal) d.base[i] = reg_wdata;
                end
                if (off == REG_AW'(OFF_MASK + i)) begin
                    mapped = 1'b1;
                    rd     = q.mask[i];
                    if (reg_we && legal) d.mask[i] = reg_wdata;
                end
                if (off == REG_AW'(OFF_XBASE + i)) begin
                    mapped = 1'b1;
                    rd     = q.xbase[i];
                    if (reg_we && legal) d.xbase[i] = reg_wdata;
                end
            end
            d.err    = !(legal && mapped);
            d.rvalid = !reg_we;
            if (!reg_we) d.rdata = (legal && mapped) ? rd : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.ctrl <= CTRL_RESET;
        end else begin
            q <= d;
        end
    end

    assign reg_rdata  = q.rdata;
    assign reg_rvalid = q.rvalid;
    assign reg_err    = q.err;
    assign win_base   = q.base;
    assign win_mask   = q.mask;
    assign win_xbase  = q.xbase;
endmodule

// File: rtl/dwx_winsel.sv
`timescale 1ns/1ps
module dwx_winsel
    import dwx_pkg::*;
#(
    parameter int BUS_AW = 32,
    parameter int OUT_AW = 34
) (
    input  word_t [NWIN-1:0]  win_base,
    input  word_t [NWIN-1:0]  win_mask,
    input  word_t [NWIN-1:0]  win_xbase,
    input  logic [BUS_AW-1:0] bus_addr,
    output logic              hit,
    output logic              use_pt,
    output logic [OUT_AW-1:0] direct_addr,
    output word_t             pte_addr
);
    localparam int SEL_W = (NWIN > 1) ? $clog2(NWIN) : 1;

    word_t             bus64;
    logic [NWIN-1:0]   armed;
    logic [NWIN-1:0]   pt_mode;
    word_t             dres [NWIN];
    word_t             pres [NWIN];
    logic [SEL_W-1:0]  sel;

    assign bus64 = 64'(bus_addr);

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        word_t cmp_m, fld, keep, tb_m, ba_m;
        assign fld        = win_mask[g] & CMP_FIELD;
        assign cmp_m      = ~win_mask[g] & CMP_FIELD;
        assign armed[g]   = (((bus64 ^ win_base[g]) & cmp_m) == '0) && win_base[g][0];
        assign pt_mode[g] = win_base[g][1];
        assign keep       = fld | LOW_KEEP;
        assign dres[g]    = (win_xbase[g] & ~keep) | (bus64 & keep);
        assign tb_m       = (fld >> 10) | PT_ALIGN;
        assign ba_m       = fld | PT_IDX;
        assign pres[g]    = (win_xbase[g] & ~tb_m) | ((bus64 & ba_m) >> 10);
    end

    always_comb begin
        sel = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (armed[i]) sel = SEL_W'(i);
        end
    end

    assign hit         = |armed;
    assign use_pt      = hit && pt_mode[sel];
    assign direct_addr = hit ? dres[sel][OUT_AW-1:0] : bus64[OUT_AW-1:0];
    assign pte_addr    = pres[sel];
endmodule

// File: rtl/dma_window_xlate.sv
`timescale 1ns/1ps
module dma_window_xlate
    import dwx_pkg::*;
#(
    parameter int REG_AW = 16,
    parameter logic [REG_AW-1:0] BLK_BASE = 'h1000,
    parameter int BUS_AW = 32,
    parameter int OUT_AW = 34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              reg_err,
    input  logic              xl_in_valid,
    output logic              xl_in_ready,
    input  logic [BUS_AW-1:0] xl_in_addr,
    output logic              xl_out_valid,
    input  logic              xl_out_ready,
    output logic [OUT_AW-1:0] xl_out_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [63:0]       mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data
);
    localparam int PG_LO = 13;

    word_t [NWIN-1:0] win_base, win_mask, win_xbase;
    logic              hit, use_pt;
    logic [OUT_AW-1:0] direct_addr;
    word_t             pte_addr;

    dwx_regs #(.REG_AW(REG_AW), .BLK_BASE(BLK_BASE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_req   (reg_req),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_size  (reg_size),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_rvalid(reg_rvalid),
        .reg_err   (reg_err),
        .win_base  (win_base),
        .win_mask  (win_mask),
        .win_xbase (win_xbase)
    );

    dwx_winsel #(.BUS_AW(BUS_AW), .OUT_AW(OUT_AW)) u_winsel (
        .win_base   (win_base),
        .win_mask   (win_mask),
        .win_xbase  (win_xbase),
        .bus_addr   (xl_in_addr),
        .hit        (hit),
        .use_pt     (use_pt),
        .direct_addr(direct_addr),
        .pte_addr   (pte_addr)
    );

    typedef struct packed {
        xl_state_e         st;
        logic [PG_LO-1:0]  lo;
        word_t             pt_addr;
        logic [OUT_AW-1:0] res;
    } xl_t;

    xl_t   q, d;
    word_t walk;

    always_comb begin
        d    = q;
        walk = ((mem_rsp_data & ~64'h1) << 12) | 64'(q.lo);
        unique case (q.st)
            ST_IDLE: begin
                if (xl_in_valid) begin
                    if (use_pt) begin
                        d.pt_addr = pte_addr;
                        d.lo      = xl_in_addr[PG_LO-1:0];
                        d.st      = ST_FETCH;
                    end else begin
                        d.res = direct_addr;
                        d.st  = ST_OUT;
                    end
                end
            end
            ST_FETCH: if (mem_req_ready) d.st = ST_WAIT;
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.res = walk[OUT_AW-1:0];
                    d.st  = ST_OUT;
                end
            end
            ST_OUT: if (xl_out_ready) d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign xl_in_ready   = (q.st == ST_IDLE);
    assign xl_out_valid  = (q.st == ST_OUT);
    assign xl_out_addr   = q.res;
    assign mem_req_valid = (q.st == ST_FETCH);
    assign mem_req_addr  = q.pt_addr;
endmodule

// File: rtl/dwx_checker.sv
`timescale 1ns/1ps
module dwx_checker #(
    parameter int OUT_AW = 34
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_rvalid,
    input logic              xl_in_ready,
    input logic              xl_out_valid,
    input logic              xl_out_ready,
    input logic [OUT_AW-1:0] xl_out_addr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [63:0]       mem_req_addr
);
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_out_valid && !xl_out_ready) |=> (xl_out_valid && $stable(xl_out_addr)));

    assert_single_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_in_ready && xl_out_valid));

    assert_fetch_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !xl_in_ready);

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    assert_read_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_req));
endmodule

bind dma_window_xlate dwx_checker #(.OUT_AW(OUT_AW)) u_dwx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_req      (reg_req),
    .reg_rvalid   (reg_rvalid),
    .xl_in_ready  (xl_in_ready),
    .xl_out_valid (xl_out_valid),
    .xl_out_ready (xl_out_ready),
    .xl_out_addr  (xl_out_addr),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr)
);

// File: tb/dma_window_xlate_tb.sv
`timescale 1ns/1ps
module dma_window_xlate_tb_top;
    localparam logic [15:0] BASE = 16'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [3:0]  reg_size = 4'd8;
    logic [63:0] reg_wdata = '0, reg_rdata;
    logic        reg_rvalid, reg_err;
    logic        xl_in_valid = 1'b0, xl_in_ready;
    logic [31:0] xl_in_addr = '0;
    logic        xl_out_valid, xl_out_ready = 1'b0;
    logic [33:0] xl_out_addr;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dma_window_xlate #(.BLK_BASE(BASE)) dut_i (.*);

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_xfer(input logic we, input logic [15:0] addr, input logic [3:0] size,
                            input logic [63:0] wd, output logic [63:0] rd, output logic err);
        @(negedge clk);
        reg_req = 1'b1; reg_we = we; reg_addr = addr; reg_size = size; reg_wdata = wd;
        @(negedge clk);
        reg_req = 1'b0; reg_we = 1'b0;
        rd = reg_rdata; err = reg_err;
    endtask

    task automatic wr(input int off, input logic [63:0] v);
        logic [63:0] rd; logic err;
        reg_xfer(1'b1, BASE + 16'(off * 64), 4'd8, v, rd, err);
        chk_eq("R2 legal write no error", 64'(err), 64'd0);
    endtask

    task automatic rdchk(input int off, input logic [63:0] exp, input string req);
        logic [63:0] rd; logic err;
        reg_xfer(1'b0, BASE + 16'(off * 64), 4'd8, '0, rd, err);
        chk_eq(req, rd, exp);
    endtask

    task automatic xlate(input logic [31:0] bus, input bit pt, input logic [63:0] exp_pte,
                         input logic [63:0] entry, input int hold, input string req,
                         input logic [33:0] exp);
        int guard;
        logic [33:0] res;
        @(negedge clk);
        xl_in_valid = 1'b1; xl_in_addr = bus;
        guard = 0;
        while (!xl_in_ready && guard < 50) begin @(negedge clk); guard++; end
        @(negedge clk);
        xl_in_valid = 1'b0;
        if (pt) begin
            chk_eq("R6 fetch issued", 64'(mem_req_valid), 64'd1);
            chk_eq("R6 input stalled during fetch", 64'(xl_in_ready), 64'd0);
            chk_eq("R6 page-table entry address", mem_req_addr, exp_pte);
            @(negedge clk);
            chk_eq("R6 request held without ready", {63'd0, mem_req_valid}, 64'd1);
            chk_eq("R6 address held without ready", mem_req_addr, exp_pte);
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            chk_eq("R6 input stalled awaiting response", 64'(xl_in_ready), 64'd0);
            mem_rsp_valid = 1'b1; mem_rsp_data = entry;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end else begin
            chk_eq("R9 no fetch for non page-table result", 64'(mem_req_valid), 64'd0);
        end
        guard = 0;
        while (!xl_out_valid && guard < 50) begin @(negedge clk); guard++; end
        res = xl_out_addr;
        chk_eq(req, 64'(res), 64'(exp));
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk_eq("R10 result held valid", 64'(xl_out_valid), 64'd1);
            chk_eq("R10 result address stable", 64'(xl_out_addr), 64'(res));
            chk_eq("R10 input not ready while pending", 64'(xl_in_ready), 64'd0);
        end
        xl_out_ready = 1'b1;
        @(negedge clk);
        xl_out_ready = 1'b0;
        chk_eq("R10 result released after ready", 64'(xl_out_valid), 64'd0);
    endtask

    task automatic t_reset;
        chk_eq("R1 input ready after reset", 64'(xl_in_ready), 64'd1);
        chk_eq("R1 no output after reset", 64'(xl_out_valid), 64'd0);
        chk_eq("R1 no memory request after reset", 64'(mem_req_valid), 64'd0);
        rdchk(0, 64'h0000_0021_0010_0000, "R1 control reset value");
        rdchk(3, 64'd0, "R1 window base reset zero");
        rdchk(11, 64'd0, "R1 translated base reset zero");
    endtask

    task automatic t_regs;
        logic [63:0] rd; logic err;
        wr(0, 64'hDEAD_BEEF_0123_4567);
        rdchk(0, 64'hDEAD_BEEF_0123_4567, "R2 control write/readback");
        reg_xfer(1'b1, BASE + 16'(3 * 64), 4'd4, 64'hFFFF_FFFF, rd, err);
        chk_eq("R2 short write flagged", 64'(err), 64'd1);
        rdchk(3, 64'd0, "R2 short write changed nothing");
        reg_xfer(1'b0, BASE + 16'(13 * 64), 4'd8, '0, rd, err);
        chk_eq("R2 unmapped offset flagged", 64'(err), 64'd1);
        reg_xfer(1'b0, BASE - 16'd64, 4'd8, '0, rd, err);
        chk_eq("R2 below-base address flagged", 64'(err), 64'd1);
        reg_xfer(1'b0, BASE + 16'(9 * 64) + 16'd8, 4'd8, '0, rd, err);
        chk_eq("R2 low address bits ignored", 64'(err), 64'd0);
    endtask

    task automatic t_passthrough;
        xlate(32'h5000_1234, 1'b0, '0, '0, 0, "R9 no window passthrough", 34'h0_5000_1234);
    endtask

    task automatic t_direct;
        wr(2, 64'h4000_0001);
        wr(6, 64'h00F0_0000);
        wr(10, 64'h2_8000_0000);
        xlate(32'h40A1_2345, 1'b0, '0, '0, 0, "R5 direct relocation", 34'h2_80A1_2345);
        xlate(32'h40FF_FFFF, 1'b0, '0, '0, 0, "R3 masked bits 23:20 ignored", 34'h2_80FF_FFFF);
        xlate(32'h4100_0000, 1'b0, '0, '0, 0, "R3 compared bit differs no match", 34'h0_4100_0000);
    endtask

    task automatic t_priority;
        wr(1, 64'h4000_0000);
        wr(5, 64'h00F0_0000);
        wr(9, 64'h1_0000_0000);
        xlate(32'h40A1_2345, 1'b0, '0, '0, 0, "R4 disabled window 0 skipped", 34'h2_80A1_2345);
        wr(1, 64'h4000_0001);
        xlate(32'h40A1_2345, 1'b0, '0, '0, 2, "R4 lowest enabled window wins", 34'h1_00A1_2345);
    endtask

    task automatic t_trunc;
        wr(3, 64'hC000_0001);
        wr(7, 64'h0);
        wr(11, 64'h0000_00F3_4560_0000);
        xlate(32'hC001_2345, 1'b0, '0, '0, 0, "R8 direct result truncated to 34 bits", 34'h3_4561_2345);
    endtask

    task automatic t_pagetable;
        wr(4, 64'h8000_0003);
        wr(8, 64'h0010_0000);
        wr(12, 64'h1234_5000);
        xlate(32'h8017_6ABC, 1'b1, 64'h1234_55D8, 64'h0000_0000_00AB_CDE1, 3,
              "R7 page-table result (R8 truncated)", 34'h2_BCDE_0ABC);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_regs();
        t_direct();
        t_priority();
        t_trunc();
        t_pagetable();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule